// File: doc/BRIEF.md
# Error Record Selector with Access Trap Check

This block holds the index that decides which error record a group of window registers reaches. The neighbouring record bank sees the index on `win_sel` and sees on `win_valid` whether that record is implemented. When `win_valid` is low, the bank returns zero for window reads and ignores window writes. The record storage itself lives outside this block.

Software reaches the index through one coprocessor-style register encoding. Reads and writes use the same encoding. Every access that matches the encoding first goes through a fixed priority chain, which gives one of four outcomes: complete, undefined, trap to the hypervisor level, or trap to the top level (or to monitor mode). The chain depends on:
- the privilege level;
- the debug-halt state;
- whether levels 2 and 3 exist and run in 32-bit mode;
- the access direction.

Writes have one extra trap bit that reads do not check. The outcome also carries a trap form flag, a syndrome code and, for a read that completes, the read data.

The controller has two states. ST_IDLE waits for an access. The transition ACCEPT (valid access with a matching encoding while idle) captures the access and its whole context and moves to ST_EVAL. In ST_EVAL the priority chain runs and, on a completed write, the index is updated. The transition RESOLVE always returns to ST_IDLE and raises the one-cycle result pulse.

Top module: `errsel_unit`

## Requirements
- R1: After reset, the index is 0, `win_valid` is 1 and `res_valid` is 0.
- R2: An access is accepted only when `acc_cp`=15, `acc_opc1`=0, `acc_crn`=5, `acc_crm`=3 and `acc_opc2`=1. Any other encoding produces no result and does not change the index.
- R3: Any access at level 0 (`cur_lvl`=0) gives `res_kind`=2'b01 (undefined). The result encoding is: 00 complete, 01 undefined, 10 trap to level 2, 11 trap to level 3 or monitor.
- R4: At level 1, the following conditions give undefined ahead of every other check: halted, secure debug disabled, level 3 present, `prio_halt_undef` set, and either `top_err_trap` set or a write with `top_werr_trap` set while level 3 is in 64-bit mode. Without `prio_halt_undef`, these conditions do not override the hypervisor traps.
- R5: At level 1, when level 2 is present and `hyp_grp5_trap` or `hyp_err_trap` is set, the result is trap to level 2 with syndrome 0x03. `res_form` equals `lvl2_is32` (1 means the hypervisor-trap form). When level 2 is absent, these bits have no effect.
- R6: At level 1, when level 3 is present, `top_err_trap` gives trap to level 3. When level 3 is in 64-bit mode, `res_form`=0 and the syndrome is 0x03. When level 3 is in 32-bit mode, `res_form`=1 (monitor), the syndrome is 0, and the trap applies only when `in_monitor` is 0. If the access is halted with secure debug disabled, the result is undefined instead of the trap.
- R7: `top_werr_trap` is checked only for writes and only when level 3 is in 64-bit mode. In that case the result is the same as for the top-level error trap.
- R8: At level 2, the hypervisor trap bits are ignored. The top-level trap applies with no monitor-mode exemption.
- R9: At level 3, `top_err_trap` with `in_monitor`=0 gives trap to level 3 with `res_form`=1 and syndrome 0. Otherwise the access completes.
- R10: A completed write loads bits 15:0 of the write data into the index and drops bits 31:16. A completed read returns the index zero-extended to 32 bits. An access that does not complete leaves the index unchanged.
- R11: `win_sel` shows the index. `win_valid` is 1 exactly when the index is below `NUM_RECORDS`.
- R12: The result appears as a one-cycle `res_valid` pulse on the second rising edge after the accepting edge. While the block is in ST_EVAL, `acc_valid` is ignored. When `res_valid` is 0, the result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cp | input | 4 | Coprocessor number |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field |
| acc_opc2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| cur_lvl | input | 2 | Current privilege level |
| in_monitor | input | 1 | Processor in monitor mode |
| dbg_halted | input | 1 | Halted in debug |
| sec_dbg_dis | input | 1 | Secure debug disabled |
| lvl2_present | input | 1 | Level 2 implemented and enabled |
| lvl3_present | input | 1 | Level 3 implemented |
| lvl2_is32 | input | 1 | Level 2 runs in 32-bit mode |
| lvl3_is32 | input | 1 | Level 3 runs in 32-bit mode |
| hyp_grp5_trap | input | 1 | Hypervisor trap of register group 5 |
| hyp_err_trap | input | 1 | Hypervisor error-register trap |
| top_err_trap | input | 1 | Top-level error-register trap |
| top_werr_trap | input | 1 | Top-level error-register write trap |
| prio_halt_undef | input | 1 | Tie-off: halted undefined takes priority |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 2 | Result encoding (see R3) |
| res_form | output | 1 | Trap form flag |
| res_syndrome | output | 8 | Syndrome code |
| res_rdata | output | 32 | Read data of a completed read |
| win_sel | output | 16 | Current record index |
| win_valid | output | 1 | Index names an implemented record |

## Verification
The assertions assume reset is asserted from time zero for at least one edge. They also assume each result belongs to the single access captured two edges earlier, so checks on level 0 can rely on the captured level. The stimulus gives each access a one-cycle `acc_valid` pulse and keeps the context inputs steady until the result is seen. There is one exception, the deliberate back-to-back request that checks the busy-ignore behaviour, and it also produces exactly one result. All four level values and every trap bit combination that the requirements name are driven; no other context is used.

// File: rtl/errsel_pkg.sv
package errsel_pkg;

    typedef enum logic [1:0] {
        K_DONE  = 2'b00,
        K_UNDEF = 2'b01,
        K_TRAP2 = 2'b10,
        K_TRAP3 = 2'b11
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } state_e;

    // Access context captured at acceptance
    typedef struct packed {
        logic [1:0] lvl;
        logic       wr;
        logic       mon;
        logic       halted;
        logic       sdd;
        logic       l2p;
        logic       l3p;
        logic       l2_32;
        logic       l3_32;
        logic       grp5;
        logic       hyperr;
        logic       toperr;
        logic       topwerr;
        logic       prio;
    } ctx_t;

    localparam int SYN_SYSACC = 3;

    localparam int CP_W   = 4;
    localparam int OPC1_W = 3;
    localparam int CRN_W  = 4;
    localparam int CRM_W  = 4;
    localparam int OPC2_W = 3;

endpackage

// File: rtl/errsel_decode.sv
module errsel_decode
    import errsel_pkg::*;
#(
    parameter int MY_CP   = 15,
    parameter int MY_OPC1 = 0,
    parameter int MY_CRN  = 5,
    parameter int MY_CRM  = 3,
    parameter int MY_OPC2 = 1
) (
    input  logic [CP_W-1:0]   cp,
    input  logic [OPC1_W-1:0] opc1,
    input  logic [CRN_W-1:0]  crn,
    input  logic [CRM_W-1:0]  crm,
    input  logic [OPC2_W-1:0] opc2,
    output logic              hit
);
    assign hit = (cp   == CP_W'(MY_CP))
              && (opc1 == OPC1_W'(MY_OPC1))
              && (crn  == CRN_W'(MY_CRN))
              && (crm  == CRM_W'(MY_CRM))
              && (opc2 == OPC2_W'(MY_OPC2));
endmodule

// File: rtl/errsel_trap_chain.sv
module errsel_trap_chain
    import errsel_pkg::*;
#(
    parameter int SYN_W = 8
) (
    input  ctx_t             c,
    output kind_e            kind,
    output logic             form,
    output logic [SYN_W-1:0] syn
);
    logic hs;        // halted with secure debug disabled
    logic werr_hit;  // write-only top-level trap applies
    logic early;     // configurable-priority undefined
    logic top_l1;
    logic top_l2;

    assign hs       = c.halted & c.sdd;
    assign werr_hit = c.wr & c.l3p & ~c.l3_32 & c.topwerr;
    assign early    = hs & c.l3p & c.prio & (c.toperr | werr_hit);
    assign top_l1   = (c.l3p & c.toperr & (~c.l3_32 | ~c.mon)) | werr_hit;
    assign top_l2   = (c.l3p & c.toperr) | werr_hit;

    always_comb begin
        kind = K_DONE;
        form = 1'b0;
        syn  = '0;
        unique case (c.lvl)
            2'd0: kind = K_UNDEF;
            2'd1: begin
                if (early) begin
                    kind = K_UNDEF;
                end else if (c.l2p & (c.grp5 | c.hyperr)) begin
                    kind = K_TRAP2;
                    form = c.l2_32;
                    syn  = SYN_W'(SYN_SYSACC);
                end else if (top_l1) begin
                    if (hs) begin
                        kind = K_UNDEF;
                    end else begin
                        kind = K_TRAP3;
                        form = c.l3_32;
                        syn  = c.l3_32 ? '0 : SYN_W'(SYN_SYSACC);
                    end
                end
            end
            2'd2: begin
                if (early) begin
                    kind = K_UNDEF;
                end else if (top_l2) begin
                    if (hs) begin
                        kind = K_UNDEF;
                    end else begin
                        kind = K_TRAP3;
                        form = c.l3_32;
                        syn  = c.l3_32 ? '0 : SYN_W'(SYN_SYSACC);
                    end
                end
            end
            2'd3: begin
                if (~c.mon & c.toperr) begin
                    kind = K_TRAP3;
                    form = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/errsel_sel_reg.sv
module errsel_sel_reg #(
    parameter int IDX_W       = 16,
    parameter int NUM_RECORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wdata,
    output logic [IDX_W-1:0] sel,
    output logic             win_valid
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_RECORDS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (we) begin
            sel <= wdata;
        end
    end

    assign win_valid = ({1'b0, sel} < LIMIT);
endmodule

// File: rtl/errsel_unit.sv
module errsel_unit
    import errsel_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 16,
    parameter int NUM_RECORDS = 8,
    parameter int SYN_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [3:0]        acc_cp,
    input  logic [2:0]        acc_opc1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_opc2,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [1:0]        cur_lvl,
    input  logic              in_monitor,
    input  logic              dbg_halted,
    input  logic              sec_dbg_dis,
    input  logic              lvl2_present,
    input  logic              lvl3_present,
    input  logic              lvl2_is32,
    input  logic              lvl3_is32,
    input  logic              hyp_grp5_trap,
    input  logic              hyp_err_trap,
    input  logic              top_err_trap,
    input  logic              top_werr_trap,
    input  logic              prio_halt_undef,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic              res_form,
    output logic [SYN_W-1:0]  res_syndrome,
    output logic [DATA_W-1:0] res_rdata,
    output logic [IDX_W-1:0]  win_sel,
    output logic              win_valid
);
    state_e            state_q;
    ctx_t              ctx_in;
    ctx_t              req_q;
    logic [IDX_W-1:0]  wdata_q;
    logic              enc_hit;
    logic              acc_take;
    kind_e             chain_kind;
    logic              chain_form;
    logic [SYN_W-1:0]  chain_syn;
    logic              sel_we;
    logic [DATA_W-1:0] rd_word;
    logic [1:0]        q_lvl;

    assign ctx_in = '{lvl: cur_lvl, wr: acc_write, mon: in_monitor,
                      halted: dbg_halted, sdd: sec_dbg_dis,
                      l2p: lvl2_present, l3p: lvl3_present,
                      l2_32: lvl2_is32, l3_32: lvl3_is32,
                      grp5: hyp_grp5_trap, hyperr: hyp_err_trap,
                      toperr: top_err_trap, topwerr: top_werr_trap,
                      prio: prio_halt_undef};
    assign q_lvl = req_q.lvl;

    errsel_decode u_decode (
        .cp   (acc_cp),
        .opc1 (acc_opc1),
        .crn  (acc_crn),
        .crm  (acc_crm),
        .opc2 (acc_opc2),
        .hit  (enc_hit)
    );

    errsel_trap_chain #(.SYN_W(SYN_W)) u_chain (
        .c    (req_q),
        .kind (chain_kind),
        .form (chain_form),
        .syn  (chain_syn)
    );

    assign acc_take = (state_q == ST_IDLE) && acc_valid && enc_hit;
    assign sel_we   = (state_q == ST_EVAL) && (chain_kind == K_DONE) && req_q.wr;

    errsel_sel_reg #(.IDX_W(IDX_W), .NUM_RECORDS(NUM_RECORDS)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (sel_we),
        .wdata     (wdata_q),
        .sel       (win_sel),
        .win_valid (win_valid)
    );

    // Reserved upper bits read as zero
    generate
        if (DATA_W > IDX_W) begin : g_pad
            assign rd_word = {{(DATA_W-IDX_W){1'b0}}, win_sel};
        end else begin : g_trunc
            assign rd_word = win_sel[DATA_W-1:0];
        end
    endgenerate

    // State register: ACCEPT and RESOLVE transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (acc_take) state_q <= ST_EVAL;
                ST_EVAL: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture of the access context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            wdata_q <= '0;
        end else if (acc_take) begin
            req_q   <= ctx_in;
            wdata_q <= acc_wdata[IDX_W-1:0];
        end
    end

    // Result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_kind     <= 2'b00;
            res_form     <= 1'b0;
            res_syndrome <= '0;
            res_rdata    <= '0;
        end else if (state_q == ST_EVAL) begin
            res_valid    <= 1'b1;
            res_kind     <= chain_kind;
            res_form     <= chain_form;
            res_syndrome <= chain_syn;
            res_rdata    <= (chain_kind == K_DONE && !req_q.wr) ? rd_word : '0;
        end else begin
            res_valid    <= 1'b0;
            res_kind     <= 2'b00;
            res_form     <= 1'b0;
            res_syndrome <= '0;
            res_rdata    <= '0;
        end
    end
endmodule

// File: rtl/errsel_unit_chk.sv
module errsel_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 16,
    parameter int SYN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [1:0]        res_kind,
    input logic              res_form,
    input logic [SYN_W-1:0]  res_syndrome,
    input logic [DATA_W-1:0] res_rdata,
    input logic [IDX_W-1:0]  win_sel,
    input logic [1:0]        q_lvl
);
    AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(q_lvl) == 2'd0) |-> res_kind == 2'b01); // R3

    AST_TRAP2_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'b10) |-> res_syndrome == SYN_W'(3)); // R5

    AST_TRAP3_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'b11) |-> res_syndrome == (res_form ? SYN_W'(0) : SYN_W'(3))); // R6

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rdata >> IDX_W) == '0); // R10

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel != $past(win_sel)) |-> (res_valid && res_kind == 2'b00)); // R10

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_rdata == '0 && res_syndrome == '0 && res_kind == 2'b00)); // R12
endmodule

bind errsel_unit errsel_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SYN_W(SYN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid    (res_valid),
    .res_kind     (res_kind),
    .res_form     (res_form),
    .res_syndrome (res_syndrome),
    .res_rdata    (res_rdata),
    .win_sel      (win_sel),
    .q_lvl        (q_lvl)
);

// File: tb/errsel_unit_test.sv
`timescale 1ns/1ps
module errsel_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_cp = 4'd15;
    logic [2:0]  acc_opc1 = 3'd0;
    logic [3:0]  acc_crn = 4'd5, acc_crm = 4'd3;
    logic [2:0]  acc_opc2 = 3'd1;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  cur_lvl = 2'd1;
    logic in_monitor = 0, dbg_halted = 0, sec_dbg_dis = 0;
    logic lvl2_present = 0, lvl3_present = 0, lvl2_is32 = 0, lvl3_is32 = 0;
    logic hyp_grp5_trap = 0, hyp_err_trap = 0, top_err_trap = 0, top_werr_trap = 0;
    logic prio_halt_undef = 0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic        res_form;
    logic [7:0]  res_syndrome;
    logic [31:0] res_rdata;
    logic [15:0] win_sel;
    logic        win_valid;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [1:0]  kind;
        logic        form;
        logic [7:0]  syn;
        logic [31:0] rdata;
        string       tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [1:0] D = 2'b00, U = 2'b01, T2 = 2'b10, T3 = 2'b11;

    always #2 clk = ~clk;

    errsel_unit uut (.*);

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected result actual=kind%0d expected=none", res_kind);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (res_kind !== e.kind || res_form !== e.form ||
                    res_syndrome !== e.syn || res_rdata !== e.rdata) begin
                    fails++;
                    $display("FAIL %s actual=k%0d f%0d s%h d%h expected=k%0d f%0d s%h d%h",
                             e.tag, res_kind, res_form, res_syndrome, res_rdata,
                             e.kind, e.form, e.syn, e.rdata);
                end
            end
        end
    end

    task automatic clr_ctx();
        cur_lvl = 2'd1; in_monitor = 0; dbg_halted = 0; sec_dbg_dis = 0;
        lvl2_present = 0; lvl3_present = 0; lvl2_is32 = 0; lvl3_is32 = 0;
        hyp_grp5_trap = 0; hyp_err_trap = 0; top_err_trap = 0; top_werr_trap = 0;
        prio_halt_undef = 0;
        acc_cp = 4'd15; acc_opc1 = 3'd0; acc_crn = 4'd5; acc_crm = 4'd3; acc_opc2 = 3'd1;
    endtask

    task automatic acc(input logic wr, input logic [31:0] wd, input logic [1:0] ek,
                       input logic ef, input logic [7:0] es, input logic [31:0] er,
                       input string tag, input bit want = 1'b1);
        exp_t e;
        e.kind = ek; e.form = ef; e.syn = es; e.rdata = er; e.tag = tag;
        if (want) sb.push_back(e);
        @(negedge clk);
        acc_write = wr; acc_wdata = wd; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 res_valid after reset", {31'b0, res_valid}, 32'd0);
        check_eq("R1 index after reset", {16'b0, win_sel}, 32'd0);
        check_eq("R11 window valid after reset", {31'b0, win_valid}, 32'd1);

        clr_ctx();
        acc(0, 0, D, 0, 8'h00, 32'h0, "R10 read after reset");
        acc(1, 32'hABCD_0004, D, 0, 8'h00, 32'h0, "R10 write");
        check_eq("R10 index after write", {16'b0, win_sel}, 32'd4);
        check_eq("R11 index 4 valid", {31'b0, win_valid}, 32'd1);
        acc(0, 0, D, 0, 8'h00, 32'h4, "R10 read back");

        acc_crm = 4'd4; acc(1, 32'h7, D, 0, 0, 0, "R2 bad crm", 1'b0); acc_crm = 4'd3;
        acc_cp = 4'd14; acc(1, 32'h7, D, 0, 0, 0, "R2 bad cp", 1'b0); acc_cp = 4'd15;
        acc(0, 0, D, 0, 8'h00, 32'h4, "R2 unmatched ignored");

        cur_lvl = 2'd0;
        acc(0, 0, U, 0, 8'h00, 32'h0, "R3 level 0 read");
        acc(1, 32'h9, U, 0, 8'h00, 32'h0, "R3 level 0 write");
        cur_lvl = 2'd1;
        acc(0, 0, D, 0, 8'h00, 32'h4, "R10 unchanged after undefined");

        lvl2_present = 1; hyp_grp5_trap = 1;
        acc(0, 0, T2, 0, 8'h03, 32'h0, "R5 group 5 trap 64-bit");
        lvl2_is32 = 1;
        acc(0, 0, T2, 1, 8'h03, 32'h0, "R5 group 5 trap 32-bit");
        lvl2_is32 = 0; hyp_grp5_trap = 0; hyp_err_trap = 1;
        acc(0, 0, T2, 0, 8'h03, 32'h0, "R5 error trap");
        lvl2_present = 0;
        acc(0, 0, D, 0, 8'h00, 32'h4, "R5 level 2 absent");

        clr_ctx();
        lvl2_present = 1; hyp_grp5_trap = 1; lvl3_present = 1; top_err_trap = 1;
        dbg_halted = 1; sec_dbg_dis = 1; prio_halt_undef = 1;
        acc(0, 0, U, 0, 8'h00, 32'h0, "R4 priority undefined");
        prio_halt_undef = 0;
        acc(0, 0, T2, 0, 8'h03, 32'h0, "R4 option off");

        clr_ctx();
        lvl3_present = 1; top_err_trap = 1;
        acc(0, 0, T3, 0, 8'h03, 32'h0, "R6 top trap 64-bit");
        dbg_halted = 1; sec_dbg_dis = 1;
        acc(0, 0, U, 0, 8'h00, 32'h0, "R6 halted becomes undefined");
        dbg_halted = 0; sec_dbg_dis = 0; lvl3_is32 = 1;
        acc(0, 0, T3, 1, 8'h00, 32'h0, "R6 monitor trap");
        in_monitor = 1;
        acc(0, 0, D, 0, 8'h00, 32'h4, "R6 already in monitor");

        clr_ctx();
        lvl3_present = 1; top_werr_trap = 1;
        acc(0, 0, D, 0, 8'h00, 32'h4, "R7 read ignores write trap");
        acc(1, 32'h5, T3, 0, 8'h03, 32'h0, "R7 write trapped");
        check_eq("R7 index kept after trap", {16'b0, win_sel}, 32'd4);
        lvl3_is32 = 1;
        acc(1, 32'h5, D, 0, 8'h00, 32'h0, "R7 32-bit top level");
        check_eq("R7 index after completed write", {16'b0, win_sel}, 32'd5);

        clr_ctx();
        cur_lvl = 2'd2; lvl2_present = 1; hyp_grp5_trap = 1; hyp_err_trap = 1;
        acc(0, 0, D, 0, 8'h00, 32'h5, "R8 hypervisor bits skipped");
        lvl3_present = 1; top_err_trap = 1; lvl3_is32 = 1; in_monitor = 1;
        acc(0, 0, T3, 1, 8'h00, 32'h0, "R8 no monitor exemption");

        clr_ctx();
        cur_lvl = 2'd3; lvl3_present = 1; top_err_trap = 1;
        acc(0, 0, T3, 1, 8'h00, 32'h0, "R9 monitor trap at level 3");
        in_monitor = 1;
        acc(0, 0, D, 0, 8'h00, 32'h5, "R9 monitor completes");

        clr_ctx();
        acc(1, 32'h8, D, 0, 8'h00, 32'h0, "R11 write 8");
        check_eq("R11 index 8 out of range", {31'b0, win_valid}, 32'd0);
        acc(1, 32'hFFFF_0007, D, 0, 8'h00, 32'h0, "R10 write with upper bits");
        check_eq("R11 index 7 in range", {31'b0, win_valid}, 32'd1);
        acc(0, 0, D, 0, 8'h00, 32'h7, "R10 upper bits dropped");

        begin
            exp_t e;
            e.kind = D; e.form = 0; e.syn = 0; e.rdata = 0; e.tag = "R12 busy write";
            sb.push_back(e);
        end
        @(negedge clk);
        acc_write = 1; acc_wdata = 32'h5; acc_valid = 1;
        @(negedge clk);
        acc_wdata = 32'h6;
        @(negedge clk);
        acc_valid = 0;
        repeat (3) @(negedge clk);
        check_eq("R12 second request ignored while busy", {16'b0, win_sel}, 32'd5);
        check_eq("R12 idle read data zero", res_rdata, 32'd0);
        check_eq("R12 all results seen", sb.size(), 32'd0);

        finish_up();
    end
endmodule